// File: doc/BRIEF.md
# Two-Phase Instruction Sequencer with Condition Codes

This block is the control core of a small 32-bit byte-addressed machine. It holds the program counter, the instruction register, a 32-entry register file and a four-bit condition code register. Each instruction passes through a fetch phase, which reads the word at the program counter, and an execute phase, which decodes and carries out the operation and then moves the program counter on. A load adds one write-back cycle after execute.

The instruction subset covers register copies, loads and stores at absolute addresses, addition with and without flag update, decrement, test and conditional branches. Flag updates differ by instruction: plain addition keeps the flags, flag-setting addition and decrement write all four, and copies, loads, stores and tests write only N and Z. Branches read the stored flags. Memory is a single synchronous word port: read data appears in the cycle after the request.

Top module: `seq_core`

## Requirements
- R1: After reset the program counter is 0, the flags {N,Z,V,C} on `cc_flags` (bits 3..0) are all 0, and the first cycle after reset is a fetch: `mem_rd`=1 with `mem_addr`=0.
- R2: Every instruction other than a taken branch moves the program counter up by 4, so instructions execute from addresses 0, 4, 8, and so on.
- R3: Instruction fields: opcode in bits 31..28, branch condition in 27..24, register A in 23..19, register B in 18..14, a 14-bit immediate in 13..0. A load or store uses the byte address immediate*4.
- R4: Opcode 3 (plain add) writes A+B into register A and leaves all four flags unchanged.
- R5: Opcode 4 (flag-setting add) writes A+B into register A and sets N to bit 31 of the sum, Z when the sum is zero, C to the carry out of bit 31, and V when both operands have the same sign and the sum has the other sign.
- R6: Opcode 0 (copy B into A), opcode 1 (load A from memory), opcode 2 (store A to memory) and opcode 6 (test A) set N and Z from the value moved or tested and leave V and C unchanged.
- R7: Opcode 5 (decrement) writes A-1 into register A and sets flags as the flag-setting add of A and 0xFFFFFFFF: C=1 when A was nonzero, V=1 only when A was 0x80000000.
- R8: Opcode 7 (branch), when its condition holds, loads the program counter with the branch's own address plus 4 times the sign-extended immediate; when it does not, the program counter moves up by 4. Branches change no flags.
- R9: Condition codes: 0 always, 1 greater-than-zero (N=0 and Z=0), 2 Z=1, 3 Z=0, 4 V=1, 5 C=1, 6 N=1, 7 to 15 never.
- R10: Opcodes 8 to 15 change no register and no flag and only move the program counter up by 4.
- R11: A count-down loop that adds a counter N into a running total, decrements it and branches back while greater than zero stores N(N+1)/2 and runs exactly N passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address of the memory access |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data for the request of the previous cycle |
| cc_flags | output | 4 | Stored flags {N,Z,V,C} |

## Verification
The assertions assume a memory that returns read data exactly one cycle after the request and never stalls, and they assume that data-word addresses never overlap the program. The bench memory answers every request in that fixed cycle and places data at 0x100 and up, well away from the short programs. The bench sweeps every condition code against flag-setting and plain additions of boundary operands, covers every flag-changing opcode with the same operands, and runs the count-down loop for many counts.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int WORD_W  = 32;
    localparam int OPC_W   = 4;
    localparam int CND_W   = 4;
    localparam int REG_AW  = 5;
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int CND_LSB = OPC_LSB - CND_W;
    localparam int RA_LSB  = CND_LSB - REG_AW;
    localparam int RB_LSB  = RA_LSB - REG_AW;
    localparam int IMM_W   = RB_LSB;
    localparam int STEP    = 4;

    localparam logic [OPC_W-1:0] OP_COPY   = 4'd0;
    localparam logic [OPC_W-1:0] OP_LOAD   = 4'd1;
    localparam logic [OPC_W-1:0] OP_STORE  = 4'd2;
    localparam logic [OPC_W-1:0] OP_ADD    = 4'd3;
    localparam logic [OPC_W-1:0] OP_ADDF   = 4'd4;
    localparam logic [OPC_W-1:0] OP_DEC    = 4'd5;
    localparam logic [OPC_W-1:0] OP_TEST   = 4'd6;
    localparam logic [OPC_W-1:0] OP_BRANCH = 4'd7;

    localparam logic [CND_W-1:0] CC_ALWAYS = 4'd0;
    localparam logic [CND_W-1:0] CC_GT     = 4'd1;
    localparam logic [CND_W-1:0] CC_ZERO   = 4'd2;
    localparam logic [CND_W-1:0] CC_NZERO  = 4'd3;
    localparam logic [CND_W-1:0] CC_OVF    = 4'd4;
    localparam logic [CND_W-1:0] CC_CARRY  = 4'd5;
    localparam logic [CND_W-1:0] CC_NEG    = 4'd6;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_LATCH  = 2'd1,
        PH_EXEC   = 2'd2,
        PH_LOADWB = 2'd3
    } phase_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        phase_e              phase;
        logic [WORD_W-1:0]   pc;
        logic [WORD_W-1:0]   ir;
        flags_t              cc;
    } core_state_t;

endpackage

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 5,
    parameter int PORTS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [WIDTH-1:0]              wdata,
    input  logic [PORTS-1:0][ADDR_W-1:0]  raddr,
    output logic [PORTS-1:0][WIDTH-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] regs_q [DEPTH];
    logic [WIDTH-1:0] regs_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_rport
            assign rdata[p] = regs_q[raddr[p]];
        end
    endgenerate

endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output flags_t           flags
);
    logic [WIDTH:0] wide;

    always_comb begin
        wide    = {1'b0, a} + {1'b0, b};
        sum     = wide[WIDTH-1:0];
        flags.n = wide[WIDTH-1];
        flags.z = (wide[WIDTH-1:0] == '0);
        flags.c = wide[WIDTH];
        flags.v = (a[WIDTH-1] == b[WIDTH-1]) && (wide[WIDTH-1] != a[WIDTH-1]);
    end

endmodule

// File: rtl/seq_cond.sv
module seq_cond
    import seq_pkg::*;
#(
    parameter int COND_W = 4
) (
    input  logic [COND_W-1:0] cond,
    input  flags_t            cc,
    output logic              take
);
    always_comb begin
        unique case (cond)
            CC_ALWAYS: take = 1'b1;
            CC_GT:     take = !cc.n && !cc.z;
            CC_ZERO:   take = cc.z;
            CC_NZERO:  take = !cc.z;
            CC_OVF:    take = cc.v;
            CC_CARRY:  take = cc.c;
            CC_NEG:    take = cc.n;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [3:0]        cc_flags
);
    localparam int PAD_W = WORD_W - IMM_W - 2;

    core_state_t st_q, st_d;

    logic [OPC_W-1:0]              opc;
    logic [CND_W-1:0]              cnd;
    logic [REG_AW-1:0]             ra_idx, rb_idx;
    logic [IMM_W-1:0]              imm;
    logic [WORD_W-1:0]             abs_addr, br_target, pc_seq;
    logic [1:0][REG_AW-1:0]        rf_raddr;
    logic [1:0][WORD_W-1:0]        rf_rdata;
    logic [WORD_W-1:0]             val_a, val_b, alu_b, alu_sum;
    flags_t                        alu_flags;
    logic                          take;
    logic                          rf_we;
    logic [WORD_W-1:0]             rf_wdata;

    // instruction field decode
    assign opc       = st_q.ir[OPC_LSB +: OPC_W];
    assign cnd       = st_q.ir[CND_LSB +: CND_W];
    assign ra_idx    = st_q.ir[RA_LSB +: REG_AW];
    assign rb_idx    = st_q.ir[RB_LSB +: REG_AW];
    assign imm       = st_q.ir[0 +: IMM_W];
    assign abs_addr  = {{PAD_W{1'b0}}, imm, 2'b00};
    assign br_target = st_q.pc + {{PAD_W{imm[IMM_W-1]}}, imm, 2'b00};
    assign pc_seq    = st_q.pc + WORD_W'(STEP);

    assign rf_raddr[0] = ra_idx;
    assign rf_raddr[1] = rb_idx;
    assign val_a       = rf_rdata[0];
    assign val_b       = rf_rdata[1];
    assign alu_b       = (opc == OP_DEC) ? '1 : val_b;

    seq_regfile #(
        .WIDTH  (WORD_W),
        .ADDR_W (REG_AW),
        .PORTS  (2)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (ra_idx),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    seq_alu #(
        .WIDTH (WORD_W)
    ) u_alu (
        .a     (val_a),
        .b     (alu_b),
        .sum   (alu_sum),
        .flags (alu_flags)
    );

    seq_cond #(
        .COND_W (CND_W)
    ) u_cond (
        .cond (cnd),
        .cc   (st_q.cc),
        .take (take)
    );

    // next-state and outputs
    always_comb begin
        st_d      = st_q;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        mem_addr  = st_q.pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = val_a;

        unique case (st_q.phase)
            PH_FETCH: begin
                mem_rd     = 1'b1;
                st_d.phase = PH_LATCH;
            end
            PH_LATCH: begin
                st_d.ir    = mem_rdata;
                st_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                st_d.phase = PH_FETCH;
                st_d.pc    = pc_seq;
                unique case (opc)
                    OP_COPY: begin
                        rf_we     = 1'b1;
                        rf_wdata  = val_b;
                        st_d.cc.n = val_b[WORD_W-1];
                        st_d.cc.z = (val_b == '0);
                    end
                    OP_LOAD: begin
                        mem_addr   = abs_addr;
                        mem_rd     = 1'b1;
                        st_d.pc    = st_q.pc;
                        st_d.phase = PH_LOADWB;
                    end
                    OP_STORE: begin
                        mem_addr  = abs_addr;
                        mem_wr    = 1'b1;
                        st_d.cc.n = val_a[WORD_W-1];
                        st_d.cc.z = (val_a == '0);
                    end
                    OP_ADD: begin
                        rf_we    = 1'b1;
                        rf_wdata = alu_sum;
                    end
                    OP_ADDF, OP_DEC: begin
                        rf_we    = 1'b1;
                        rf_wdata = alu_sum;
                        st_d.cc  = alu_flags;
                    end
                    OP_TEST: begin
                        st_d.cc.n = val_a[WORD_W-1];
                        st_d.cc.z = (val_a == '0);
                    end
                    OP_BRANCH: begin
                        if (take) begin
                            st_d.pc = br_target;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            PH_LOADWB: begin
                rf_we      = 1'b1;
                rf_wdata   = mem_rdata;
                st_d.cc.n  = mem_rdata[WORD_W-1];
                st_d.cc.z  = (mem_rdata == '0);
                st_d.pc    = pc_seq;
                st_d.phase = PH_FETCH;
            end
            default: begin
                st_d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_FETCH;
            st_q.pc    <= '0;
            st_q.ir    <= '0;
            st_q.cc    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_flags = st_q.cc;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && opc != OP_BRANCH && opc != OP_LOAD)
        |=> (st_q.pc == $past(st_q.pc) + WORD_W'(STEP)));

    // R8
    br_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && opc == OP_BRANCH && !take)
        |=> (st_q.pc == $past(st_q.pc) + WORD_W'(STEP)));

    // R8
    br_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && opc == OP_BRANCH) |=> $stable(cc_flags));

    // R4
    add_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && opc == OP_ADD) |=> $stable(cc_flags));

    // R10
    undef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && opc[OPC_W-1]) |=> ($stable(cc_flags) && !$past(rf_we)));

    // R6
    move_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC && (opc == OP_COPY || opc == OP_TEST || opc == OP_STORE))
        |=> (cc_flags[1:0] == $past(cc_flags[1:0])));

    // R5
    nz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc_flags[3] && cc_flags[2]));

    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    wb_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (st_q.phase == PH_EXEC || st_q.phase == PH_LOADWB));

endmodule

// File: tb/sim_seq_core.sv
`timescale 1ns/1ps
module sim_seq_core;

    localparam int MEM_WORDS = 128;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic [3:0]  cc_flags;

    logic [31:0] img [MEM_WORDS];
    logic [31:0] mem [MEM_WORDS];
    logic [31:0] last_fetch;
    int          dec_fetches;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    seq_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .cc_flags  (cc_flags)
    );

    // synchronous word memory, loaded from the image while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            mem <= img;
        end else if (mem_wr) begin
            mem[mem_addr[8:2]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[8:2]];
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            last_fetch  <= 32'hFFFF_FFFF;
            dec_fetches <= 0;
        end else if (mem_rd && mem_addr < 32'h100) begin
            last_fetch <= mem_addr;
            if (mem_addr == 32'd12) dec_fetches <= dec_fetches + 1;
        end
    end

    function automatic logic [31:0] enc(input int op, input int cond,
                                        input int ra, input int rb, input int imm);
        enc = {op[3:0], cond[3:0], ra[4:0], rb[4:0], imm[13:0]};
    endfunction

    function automatic logic [3:0] add_flags(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        add_flags = {s[31], s[31:0] == 32'd0, (a[31] == b[31]) && (s[31] != a[31]), s[32]};
    endfunction

    function automatic logic exp_take(input int cond, input logic [3:0] f);
        case (cond)
            0: exp_take = 1'b1;
            1: exp_take = !f[3] && !f[2];
            2: exp_take = f[2];
            3: exp_take = !f[2];
            4: exp_take = f[1];
            5: exp_take = f[0];
            6: exp_take = f[3];
            default: exp_take = 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < MEM_WORDS; i++) img[i] = 32'd0;
    endtask

    task automatic run(input int cycles, input bit check_reset);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        if (check_reset) begin
            // R1: first cycle out of reset is a fetch at 0 with clear flags
            chk(mem_rd == 1'b1, "R1 fetch", {31'd0, mem_rd}, 32'd1);
            chk(mem_addr == 32'd0, "R1 pc", mem_addr, 32'd0);
            chk(cc_flags == 4'd0, "R1 flags", {28'd0, cc_flags}, 32'd0);
        end
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    logic [31:0] vals [6];

    initial begin
        vals[0] = 32'h0000_0000;
        vals[1] = 32'h0000_0001;
        vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000;
        vals[4] = 32'hFFFF_FFFF;
        vals[5] = 32'h1234_5678;

        // R4 R5 R8 R9: both additions against every condition code
        for (int opsel = 0; opsel < 2; opsel++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    for (int cond = 0; cond < 8; cond++) begin
                        logic [3:0] ef;
                        logic       tk;
                        clear_img();
                        img[0] = enc(1, 0, 2, 0, 64);
                        img[1] = enc(1, 0, 3, 0, 65);
                        img[2] = enc(opsel == 0 ? 4 : 3, 0, 2, 3, 0);
                        img[3] = enc(7, cond, 0, 0, 2);
                        img[4] = enc(7, 0, 0, 0, 0);
                        img[5] = enc(7, 0, 0, 0, 0);
                        img[64] = vals[i];
                        img[65] = vals[j];
                        run(40, opsel == 0 && i == 0 && j == 0 && cond == 0);
                        if (opsel == 0) begin
                            ef = add_flags(vals[i], vals[j]);
                            chk(cc_flags == ef, "R5 flags", {28'd0, cc_flags}, {28'd0, ef});
                        end else begin
                            ef = {vals[j][31], vals[j] == 32'd0, 2'b00};
                            chk(cc_flags == ef, "R4 flags kept", {28'd0, cc_flags}, {28'd0, ef});
                        end
                        tk = exp_take(cond, ef);
                        chk(last_fetch == (tk ? 32'd20 : 32'd16), "R8 R9 branch",
                            last_fetch, tk ? 32'd20 : 32'd16);
                    end
                end
            end
        end

        // R6 R7 R10: test, copy, decrement, undefined opcode after a flag-setting add
        for (int kind = 0; kind < 4; kind++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [3:0] f1, ef;
                    clear_img();
                    img[0] = enc(1, 0, 2, 0, 64);
                    img[1] = enc(1, 0, 3, 0, 65);
                    img[2] = enc(4, 0, 3, 3, 0);
                    case (kind)
                        0: img[3] = enc(6, 0, 2, 0, 0);
                        1: img[3] = enc(0, 0, 4, 2, 0);
                        2: img[3] = enc(5, 0, 2, 0, 0);
                        default: img[3] = enc(9, 5, 2, 2, 0);
                    endcase
                    img[4] = enc(7, 0, 0, 0, 0);
                    img[64] = vals[i];
                    img[65] = vals[j];
                    run(40, 1'b0);
                    f1 = add_flags(vals[j], vals[j]);
                    case (kind)
                        0, 1: ef = {vals[i][31], vals[i] == 32'd0, f1[1:0]};
                        2:    ef = add_flags(vals[i], 32'hFFFF_FFFF);
                        default: ef = f1;
                    endcase
                    if (kind < 2)
                        chk(cc_flags == ef, "R6 NZ only", {28'd0, cc_flags}, {28'd0, ef});
                    else if (kind == 2)
                        chk(cc_flags == ef, "R7 decrement flags", {28'd0, cc_flags}, {28'd0, ef});
                    else
                        chk(cc_flags == ef, "R10 no effect", {28'd0, cc_flags}, {28'd0, ef});
                    // R2: sequential flow reaches the halt word at 16
                    chk(last_fetch == 32'd16, "R2 R10 pc advance", last_fetch, 32'd16);
                end
            end
        end

        // R11: count-down summing loop
        for (int n = 1; n <= 16; n++) begin
            clear_img();
            img[0] = enc(1, 0, 1, 0, 64);
            img[1] = enc(1, 0, 0, 0, 65);
            img[2] = enc(3, 0, 0, 1, 0);
            img[3] = enc(5, 0, 1, 0, 0);
            img[4] = enc(7, 1, 0, 0, -2);
            img[5] = enc(2, 0, 0, 0, 66);
            img[6] = enc(7, 0, 0, 0, 0);
            img[64] = 32'(n);
            img[65] = 32'd0;
            run(40 + n * 10, 1'b0);
            chk(mem[66] == 32'(n * (n + 1) / 2), "R11 sum", mem[66], 32'(n * (n + 1) / 2));
            chk(dec_fetches == n, "R11 passes", 32'(dec_fetches), 32'(n));
            chk(last_fetch == 32'd24, "R8 loop exit", last_fetch, 32'd24);
            // R6: store sets N,Z from the positive sum; V,C kept from decrement of 1
            chk(cc_flags == 4'b0001, "R6 store flags", {28'd0, cc_flags}, 32'd1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule